// File: doc/BRIEF.md
# Clock Doubler Control Sequencer

This block holds the software-visible control register for an on-chip frequency doubler and enforces the safe order of operations around it. A two-bit mode field chooses between three states: doubler off with the oscillator clock driving the system, doubler running in warm-up with the oscillator clock still in use, and doubler running with the doubled clock in use. When the doubler is started, a lock-up timer runs. Its length is either 2^12 or 2^10 oscillator cycles, chosen by a register bit. A read-only busy bit shows the timer state.

Illegal sequences are refused in hardware. The refused cases are:
- switching to the doubled clock before lock-up has finished;
- leaving the doubled clock and stopping the doubler in a single write;
- changing the mode while the system runs in low-speed mode.

A refused write leaves the mode unchanged and sets a sticky error bit, which software clears by writing 1 to it. The block also raises a flag if something asks to stop the oscillator while the doubler is running.

Top module: `dblr_ctrl_seq`

## Requirements
- R1: After reset the register reads 0x00: mode 00, lock busy 0, short-lock bit 0, error 0. The dbl_en, sel_dbl and osc_stop_viol outputs are all 0.
- R2: The register read layout is mode in bits [1:0], lock busy in bit 2, short-lock select in bit 3 and sticky error in bit 4. Bits [7:5] read 0. Mode 00 drives dbl_en=0 and sel_dbl=0, mode 01 drives dbl_en=1 and sel_dbl=0, and mode 10 drives dbl_en=1 and sel_dbl=1.
- R3: A write of mode 01 while the mode is 00 starts lock-up. Busy reads 1 for exactly 4096 cycles when bit 3 of that same write is 0, and for exactly 1024 cycles when it is 1.
- R4: A write of mode 10 is refused, and sets the error bit, if the mode is 00 or if lock-up is still busy.
- R5: A write of mode 00 while the mode is 10 is refused and sets the error bit. The only allowed exit from mode 10 is mode 01.
- R6: While slow_mode is 1, a write whose mode field differs from the current mode is refused and sets the error bit. A write that repeats the current mode is accepted.
- R7: A write with mode field 11 leaves the mode unchanged and does not set the error bit.
- R8: A write with bit 4 set clears the error bit, unless the same write is refused, in which case the error bit stays set. Bit 3 takes the written value on every write.
- R9: osc_stop_viol is 1 whenever osc_stop_req is 1 while dbl_en is 1. Each such cycle sets the error bit on the next clock.
- R10: sel_dbl changes only on the clock edge of an accepted register write, never while lock-up counts.
- R11: A write of mode 00 while the mode is 01 is accepted even during lock-up, and busy reads 0 after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| slow_mode | input | 1 | System runs in low-speed mode |
| osc_stop_req | input | 1 | Request to stop the high-frequency oscillator |
| dbl_en | output | 1 | Doubler enable |
| sel_dbl | output | 1 | Selects the doubled clock as system clock |
| osc_stop_viol | output | 1 | Oscillator stop requested while doubler runs |

## Verification
The hardest states to reach are a refused write that also asks to clear the error bit, and a write that lands while lock-up is still counting. The stimulus table reaches both by chaining writes. First it starts lock-up. Then, before the count can end, it writes mode 10 and an error-clear write with reserved mode. It waits for busy to drop only where the next row needs the doubled clock. The directed tests then time the full length of both lock-up windows cycle by cycle, and they drive the oscillator stop request in the running and stopped states.

// File: rtl/dblr_pkg.sv
package dblr_pkg;
  typedef enum logic [1:0] {
    MD_OFF  = 2'b00,
    MD_WARM = 2'b01,
    MD_DBL  = 2'b10,
    MD_RSVD = 2'b11
  } dbl_mode_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned BUSY_BIT = 2;
  localparam int unsigned LKTM_BIT = 3;
  localparam int unsigned ERR_BIT  = 4;
endpackage

// File: rtl/dblr_wr_filter.sv
module dblr_wr_filter
  import dblr_pkg::*;
(
  input  dbl_mode_e cur_mode,
  input  dbl_mode_e req_mode,
  input  logic      wr,
  input  logic      slow,
  input  logic      busy,
  output logic      accept,
  output logic      refuse,
  output logic      start_lock,
  output logic      abort_lock
);
  logic same, rsvd, path_ok;

  always_comb begin
    same = (req_mode == cur_mode);
    rsvd = (req_mode == MD_RSVD);
    unique case (cur_mode)
      MD_OFF:  path_ok = (req_mode == MD_WARM);
      MD_WARM: path_ok = (req_mode == MD_OFF) || ((req_mode == MD_DBL) && !busy);
      MD_DBL:  path_ok = (req_mode == MD_WARM);
      default: path_ok = 1'b0;
    endcase
    accept     = wr && !same && !rsvd && !slow && path_ok;
    refuse     = wr && !same && !rsvd && !accept;
    start_lock = accept && (cur_mode == MD_OFF) && (req_mode == MD_WARM);
    abort_lock = accept && (req_mode == MD_OFF);
  end
endmodule

// File: rtl/dblr_lock_timer.sv
module dblr_lock_timer #(
  parameter int unsigned LONG_LOG2  = 12,
  parameter int unsigned SHORT_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic short_sel,
  output logic busy
);
  localparam int unsigned CW = LONG_LOG2;
  localparam logic [CW-1:0] LONG_LOAD  = CW'((64'd1 << LONG_LOG2) - 64'd1);
  localparam logic [CW-1:0] SHORT_LOAD = CW'((64'd1 << SHORT_LOG2) - 64'd1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (start) begin
      cnt_n  = short_sel ? SHORT_LOAD : LONG_LOAD;
      busy_n = 1'b1;
    end else if (abort) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/dblr_ctrl_seq.sv
module dblr_ctrl_seq
  import dblr_pkg::*;
#(
  parameter int unsigned LONG_LOG2  = 12,
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             slow_mode,
  input  logic             osc_stop_req,
  output logic             dbl_en,
  output logic             sel_dbl,
  output logic             osc_stop_viol
);
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STG-1];

  dbl_mode_e mode_q, mode_n, req_mode;
  logic      lktm_q, lktm_n, err_q, err_n;
  logic      busy, accept, refuse, start_lock, abort_lock;

  assign req_mode = dbl_mode_e'(reg_wdata[MODE_LSB +: 2]);

  dblr_wr_filter u_filt (
    .cur_mode  (mode_q),
    .req_mode  (req_mode),
    .wr        (reg_wr),
    .slow      (slow_mode),
    .busy      (busy),
    .accept    (accept),
    .refuse    (refuse),
    .start_lock(start_lock),
    .abort_lock(abort_lock)
  );

  dblr_lock_timer #(
    .LONG_LOG2 (LONG_LOG2),
    .SHORT_LOG2(SHORT_LOG2)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start_lock),
    .abort    (abort_lock),
    .short_sel(reg_wdata[LKTM_BIT]),
    .busy     (busy)
  );

  assign osc_stop_viol = osc_stop_req && (mode_q != MD_OFF);

  always_comb begin
    mode_n = mode_q;
    lktm_n = lktm_q;
    err_n  = err_q;
    if (reg_wr) begin
      lktm_n = reg_wdata[LKTM_BIT];
      if (reg_wdata[ERR_BIT]) err_n = 1'b0;
      if (accept) mode_n = req_mode;
    end
    if (refuse || osc_stop_viol) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= MD_OFF;
      lktm_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      lktm_q <= lktm_n;
      err_q  <= err_n;
    end
  end

  assign dbl_en  = (mode_q != MD_OFF);
  assign sel_dbl = (mode_q == MD_DBL);

  always_comb begin
    reg_rdata                    = '0;
    reg_rdata[MODE_LSB +: 2]     = mode_q;
    reg_rdata[BUSY_BIT]          = busy;
    reg_rdata[LKTM_BIT]          = lktm_q;
    reg_rdata[ERR_BIT]           = err_q;
  end
endmodule

// File: rtl/dblr_ctrl_seq_chk.sv
module dblr_ctrl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       slow_mode,
  input logic       osc_stop_req,
  input logic       dbl_en,
  input logic       sel_dbl,
  input logic       osc_stop_viol
);
  // R2: doubled clock is never selected with the doubler off
  p_sel_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_dbl |-> dbl_en);

  // R5: leaving doubled clock keeps the doubler running for at least one cycle
  p_no_direct_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_dbl |=> dbl_en);

  // R4: doubled clock only entered from a finished warm-up
  p_enter_dbl_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_dbl) |-> $past(dbl_en && !reg_rdata[2]));

  // R6: no mode change out of a slow-mode cycle
  p_slow_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_mode |=> ($stable(dbl_en) && $stable(sel_dbl)));

  // R10: clock select moves only after a write
  p_sel_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(sel_dbl));

  // R9: a flagged oscillator stop leaves the error bit set
  p_osc_flag_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop_req && dbl_en) |=> reg_rdata[4]);

  // R9: no flag while the doubler is stopped
  p_osc_flag_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop_viol |-> (dbl_en && osc_stop_req));
endmodule

bind dblr_ctrl_seq dblr_ctrl_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rdata    (reg_rdata),
  .slow_mode    (slow_mode),
  .osc_stop_req (osc_stop_req),
  .dbl_en       (dbl_en),
  .sel_dbl      (sel_dbl),
  .osc_stop_viol(osc_stop_viol)
);

// File: tb/sim_dblr_ctrl_seq.sv
`timescale 1ns/1ps
module sim_dblr_ctrl_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       slow_mode = 1'b0;
  logic       osc_stop_req = 1'b0;
  logic       dbl_en, sel_dbl, osc_stop_viol;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dblr_ctrl_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .slow_mode(slow_mode), .osc_stop_req(osc_stop_req),
    .dbl_en(dbl_en), .sel_dbl(sel_dbl), .osc_stop_viol(osc_stop_viol)
  );

  // {slow, wait_unlocked, wdata, expected rdata}
  localparam logic [17:0] VEC [14] = '{
    {1'b0, 1'b0, 8'h02, 8'h10},  // R4 off -> dbl refused
    {1'b0, 1'b0, 8'h11, 8'h05},  // R3 R8 start lock, clear err
    {1'b0, 1'b0, 8'h02, 8'h15},  // R4 dbl while busy refused
    {1'b0, 1'b0, 8'h13, 8'h05},  // R7 reserved ignored, err cleared
    {1'b0, 1'b1, 8'h02, 8'h02},  // R2 dbl after lock
    {1'b0, 1'b0, 8'h00, 8'h12},  // R5 dbl -> off refused
    {1'b1, 1'b0, 8'h11, 8'h12},  // R6 R8 slow refuse beats clear
    {1'b1, 1'b0, 8'h12, 8'h02},  // R6 same mode in slow accepted
    {1'b0, 1'b0, 8'h01, 8'h01},  // R2 dbl -> warm, no new lock
    {1'b0, 1'b0, 8'h00, 8'h00},  // R2 warm -> off
    {1'b0, 1'b0, 8'h09, 8'h0D},  // R3 short lock start
    {1'b0, 1'b0, 8'h08, 8'h08},  // R11 abort mid-lock
    {1'b1, 1'b0, 8'h09, 8'h18},  // R6 slow start refused
    {1'b0, 1'b0, 8'h10, 8'h00}   // R8 clear err, short bit to 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk);
    slow_mode = s; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; slow_mode = 1'b0;
  endtask

  task automatic wait_unlock();
    while (reg_rdata[2]) @(negedge clk);
  endtask

  task automatic time_lock(input string req, input int exp_len);
    int n = 0;
    while (reg_rdata[2]) begin n++; @(negedge clk); end
    chk(req, n, exp_len);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 outs", {dbl_en, sel_dbl, osc_stop_viol}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after release", reg_rdata, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i][16]) wait_unlock();
      wr_reg(VEC[i][17], VEC[i][15:8]);
      chk($sformatf("R2 table row %0d", i), reg_rdata, VEC[i][7:0]);
      chk($sformatf("R2 outs row %0d", i), {dbl_en, sel_dbl},
          {VEC[i][1:0] != 2'b00, VEC[i][1:0] == 2'b10});
    end

    // R9 oscillator stop while running
    wr_reg(1'b0, 8'h01);
    @(negedge clk); osc_stop_req = 1'b1; #1;
    chk("R9 viol running", osc_stop_viol, 1'b1);
    @(negedge clk); osc_stop_req = 1'b0;
    chk("R9 err set", reg_rdata[4], 1'b1);
    chk("R10 sel held in lock", sel_dbl, 1'b0);
    wr_reg(1'b0, 8'h10);
    chk("R11 abort clears", reg_rdata, 8'h00);
    osc_stop_req = 1'b1; #1;
    chk("R9 no viol when off", osc_stop_viol, 1'b0);
    @(negedge clk); osc_stop_req = 1'b0;
    chk("R9 no err when off", reg_rdata[4], 1'b0);

    // R3 lock lengths
    wr_reg(1'b0, 8'h01);
    time_lock("R3 long lock", 4096);
    chk("R3 mode after long lock", reg_rdata, 8'h01);
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b0, 8'h09);
    time_lock("R3 short lock", 1024);
    wr_reg(1'b0, 8'h0A);
    chk("R2 dbl after short lock", {reg_rdata, dbl_en, sel_dbl}, {8'h0A, 2'b11});

    // R1 reset mid-operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset", {reg_rdata, dbl_en, sel_dbl}, {8'h00, 2'b00});
    finish_run();
  end
endmodule